// File: doc/BRIEF.md
# Sectioned Register Bank with Time Snapshot

This block holds a byte-wide bank of 26 locations behind an already-decoded serial transaction interface. The interface delivers single-cycle strobes: a transaction start, an address byte, a write byte and a read request. A single address pointer serves every access. An address byte loads the pointer. Each accepted write or read moves the pointer forward by one, and the move never leaves the section the pointer is in.

The bank has four sections:

| Section | Addresses |
|---|---|
| Timekeeping | 00h–06h |
| Control/status | 07h–0Bh |
| Alarm | 0Ch–11h |
| User | 12h–19h |

The timekeeping locations are not stored here. An external time counter presents them on a parallel input. Every transaction start copies that input into a shadow buffer, and all reads of timekeeping locations return the buffer. A counter tick during a multi-byte read therefore cannot tear the value. A write to a timekeeping location is passed to the counter as a one-cycle load pulse that carries the index and the value. The pulse is raised only while the write-enable bit, bit 4 of location 07h, is set. The other three sections are kept in local flops and accept writes at any time.

The pointer is not cleared when a transaction ends. A later read with no address byte therefore continues where the previous transfer stopped.

Top module: `rbk_bank`

## Requirements
- R1: After reset the pointer is 00h, every stored location reads 00h, `rd_valid` and `time_load` are 0, and the shadow buffer holds 00h in every entry except entry 3 (date), which holds 01h.
- R2: An address byte of 19h or below loads the pointer. An address byte above 19h is ignored: the pointer keeps its value and no location changes.
- R3: A read request returns the byte at the pointer on `rd_data`, with `rd_valid` high, one cycle after the request. The pointer then advances.
- R4: Each accepted read or write advances the pointer by one. From the last address of a section the pointer wraps to the first address of the same section: 06h→00h, 0Bh→07h, 11h→0Ch, 19h→12h.
- R5: A write to locations 00h–06h while bit 4 of location 07h is 1 produces, one cycle later, a single-cycle `time_load` pulse. The pulse carries `time_load_idx` equal to the location (3 bits) and `time_load_val` equal to the written byte.
- R6: A write to locations 00h–06h while bit 4 of location 07h is 0 is discarded and produces no `time_load` pulse. The pointer still advances.
- R7: Writes to locations 07h–19h are stored whatever the value of the write-enable bit, and read back unchanged.
- R8: On each `xfer_start` the shadow buffer takes the value `time_in` presents at that clock edge, with byte i at bits [8i+7:8i]. Reads of 00h–06h return the buffer, and later changes of `time_in` are not seen until the next start.
- R9: The pointer keeps its value across transactions, so a read with no address byte continues at the location after the last one accessed.
- R10: If strobes coincide, the address byte takes priority over a write, and a write takes priority over a read request. The losing strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | Transaction start strobe; refreshes the shadow buffer |
| addr_valid | input | 1 | Address byte strobe |
| addr_byte | input | 8 | Address byte |
| wr_valid | input | 1 | Write byte strobe |
| wr_data | input | 8 | Write byte |
| rd_req | input | 1 | Read byte request strobe |
| time_in | input | 56 | Live timekeeping bytes from the external counter, byte i at bits [8i+7:8i] |
| rd_valid | output | 1 | Read data valid, one cycle after a request |
| rd_data | output | 8 | Read data byte |
| time_load | output | 1 | One-cycle pulse loading a time byte into the counter |
| time_load_idx | output | 3 | Timekeeping index being loaded |
| time_load_val | output | 8 | Value being loaded |

## Verification
The main same-cycle collision is a transaction start on the clock edge where the external counter changes its value. The bench changes `time_in` and pulses `xfer_start` on the same driving edge. It then expects the new value from the buffer and the old one from a start that came earlier. A second collision is an address byte arriving together with a write or read strobe. The bench judges it by reading the target location afterwards and by confirming that no read data was returned.

// File: rtl/rbk_pkg.sv
package rbk_pkg;

   localparam int RBK_NUM_SEC = 4;
   localparam int RBK_TOTAL   = 26;
   localparam int RBK_SEC_BASE [RBK_NUM_SEC] = '{0, 7, 12, 18};

   typedef enum logic [1:0] {SEC_TIME, SEC_CTRL, SEC_ALARM, SEC_USER} sec_e;

   function automatic int sec_of(input int a);
      int s;
      s = 0;
      for (int i = 0; i < RBK_NUM_SEC; i++)
         if (a >= RBK_SEC_BASE[i]) s = i;
      return s;
   endfunction

   function automatic int sec_end(input int s);
      int e;
      e = RBK_TOTAL - 1;
      for (int i = 0; i < RBK_NUM_SEC - 1; i++)
         if (s == i) e = RBK_SEC_BASE[i+1] - 1;
      return e;
   endfunction

   function automatic int next_addr(input int a);
      int s;
      s = sec_of(a);
      return (a == sec_end(s)) ? RBK_SEC_BASE[s] : a + 1;
   endfunction

endpackage

// File: rtl/rbk_ptr.sv
module rbk_ptr #(
   parameter int DW       = 8,
   parameter int AW       = 5,
   parameter int NUM_REGS = 26
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] load_byte,
   input  logic          step,
   output logic [AW-1:0] ptr
);
   localparam logic [DW-1:0] LAST_B = DW'(NUM_REGS - 1);

   logic          load_ok;
   logic [AW-1:0] ptr_next;

   assign load_ok  = load && (load_byte <= LAST_B);
   assign ptr_next = AW'(rbk_pkg::next_addr(int'(ptr)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (load) begin
         if (load_ok) ptr <= load_byte[AW-1:0];
      end
      else if (step)
         ptr <= ptr_next;
   end
endmodule

// File: rtl/rbk_snap.sv
module rbk_snap #(
   parameter int DW       = 8,
   parameter int TIME_CNT = 7,
   parameter int DATE_IDX = 3,
   parameter int DATE_RST = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   take,
   input  logic [TIME_CNT*DW-1:0] live,
   output logic [TIME_CNT*DW-1:0] snap
);
   for (genvar i = 0; i < TIME_CNT; i++) begin : g_ent
      if (i == DATE_IDX) begin : g_date
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    snap[i*DW +: DW] <= DW'(DATE_RST);
            else if (take) snap[i*DW +: DW] <= live[i*DW +: DW];
         end
      end else begin : g_zero
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    snap[i*DW +: DW] <= '0;
            else if (take) snap[i*DW +: DW] <= live[i*DW +: DW];
         end
      end
   end
endmodule

// File: rtl/rbk_regs.sv
module rbk_regs #(
   parameter int DW       = 8,
   parameter int AW       = 5,
   parameter int NUM_REGS = 26,
   parameter int BASE     = 7,
   parameter int CTL_REG  = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wen,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata,
   output logic [DW-1:0] ctl
);
   localparam logic [AW-1:0] LAST_A = AW'(NUM_REGS - 1);

   logic [DW-1:0] mem [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_loc
      if (i < BASE) begin : g_none
         assign mem[i] = '0;
      end else begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem[i] <= '0;
            else if (wen && (waddr == AW'(i)))
               mem[i] <= wdata;
         end
      end
   end

   assign rdata = (raddr <= LAST_A) ? mem[raddr] : '0;
   assign ctl   = mem[CTL_REG];
endmodule

// File: rtl/rbk_bank.sv
module rbk_bank #(
   parameter int DW       = 8,
   parameter int AW       = 5,
   parameter int NUM_REGS = 26,
   parameter int TIME_CNT = 7,
   parameter int WE_REG   = 7,
   parameter int WE_BIT   = 4,
   parameter int DATE_IDX = 3,
   parameter int DATE_RST = 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          xfer_start,
   input  logic                          addr_valid,
   input  logic [DW-1:0]                 addr_byte,
   input  logic                          wr_valid,
   input  logic [DW-1:0]                 wr_data,
   input  logic                          rd_req,
   input  logic [TIME_CNT*DW-1:0]        time_in,
   output logic                          rd_valid,
   output logic [DW-1:0]                 rd_data,
   output logic                          time_load,
   output logic [$clog2(TIME_CNT)-1:0]   time_load_idx,
   output logic [DW-1:0]                 time_load_val
);
   localparam int TIW = $clog2(TIME_CNT);
   localparam logic [AW-1:0] TIME_LAST = AW'(TIME_CNT - 1);

   if (NUM_REGS != rbk_pkg::RBK_TOTAL) begin : g_chk_total
      $error("NUM_REGS must match the section table");
   end
   if (TIME_CNT != rbk_pkg::RBK_SEC_BASE[1]) begin : g_chk_time
      $error("TIME_CNT must match the first section size");
   end
   if ((1 << AW) < NUM_REGS || AW < TIW || AW > DW) begin : g_chk_aw
      $error("AW does not fit the register count");
   end
   if (WE_REG < TIME_CNT || WE_REG >= NUM_REGS || WE_BIT >= DW) begin : g_chk_we
      $error("write-enable location out of range");
   end
   if (DATE_IDX >= TIME_CNT) begin : g_chk_date
      $error("date index out of range");
   end

   logic                   slot_wr, slot_rd, in_time, we_flag, regs_wen, load_now;
   logic [AW-1:0]          ptr;
   logic [DW-1:0]          regs_rdata, ctl_byte, snap_word, rd_word;
   logic [TIME_CNT*DW-1:0] snap_flat;

   assign slot_wr  = wr_valid && !addr_valid;
   assign slot_rd  = rd_req && !addr_valid && !wr_valid;
   assign in_time  = (ptr <= TIME_LAST);
   assign we_flag  = ctl_byte[WE_BIT];
   assign regs_wen = slot_wr && !in_time;
   assign load_now = slot_wr && in_time && we_flag;

   rbk_ptr #(.DW(DW), .AW(AW), .NUM_REGS(NUM_REGS)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(addr_valid), .load_byte(addr_byte),
      .step(slot_wr || slot_rd), .ptr(ptr));

   rbk_snap #(.DW(DW), .TIME_CNT(TIME_CNT), .DATE_IDX(DATE_IDX), .DATE_RST(DATE_RST)) u_snap (
      .clk(clk), .rst_n(rst_n), .take(xfer_start), .live(time_in), .snap(snap_flat));

   rbk_regs #(.DW(DW), .AW(AW), .NUM_REGS(NUM_REGS), .BASE(TIME_CNT), .CTL_REG(WE_REG)) u_regs (
      .clk(clk), .rst_n(rst_n), .wen(regs_wen), .waddr(ptr), .wdata(wr_data),
      .raddr(ptr), .rdata(regs_rdata), .ctl(ctl_byte));

   always_comb begin
      snap_word = '0;
      for (int i = 0; i < TIME_CNT; i++)
         if (ptr == AW'(i)) snap_word = snap_flat[i*DW +: DW];
   end

   assign rd_word = in_time ? snap_word : regs_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid      <= 1'b0;
         rd_data       <= '0;
         time_load     <= 1'b0;
         time_load_idx <= '0;
         time_load_val <= '0;
      end else begin
         rd_valid  <= slot_rd;
         time_load <= load_now;
         if (slot_rd) rd_data <= rd_word;
         if (load_now) begin
            time_load_idx <= ptr[TIW-1:0];
            time_load_val <= wr_data;
         end
      end
   end
endmodule

// File: rtl/rbk_bank_chk.sv
module rbk_bank_chk #(
   parameter int DW       = 8,
   parameter int AW       = 5,
   parameter int NUM_REGS = 26,
   parameter int TIME_CNT = 7
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   xfer_start,
   input logic                   addr_valid,
   input logic [DW-1:0]          addr_byte,
   input logic                   wr_valid,
   input logic                   rd_req,
   input logic                   rd_valid,
   input logic                   time_load,
   input logic [AW-1:0]          ptr,
   input logic                   we_flag,
   input logic [TIME_CNT*DW-1:0] snap_flat
);
   localparam logic [AW-1:0] LAST_A    = AW'(NUM_REGS - 1);
   localparam logic [DW-1:0] LAST_B    = DW'(NUM_REGS - 1);
   localparam logic [AW-1:0] TIME_LAST = AW'(TIME_CNT - 1);

   assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= LAST_A);

   assert_bad_addr_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && addr_byte > LAST_B) |=> $stable(ptr));

   assert_rd_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_req && !addr_valid && !wr_valid));

   assert_wrap_in_section_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_valid && (wr_valid || rd_req)) |=>
      (rbk_pkg::sec_of(int'(ptr)) == $past(rbk_pkg::sec_of(int'(ptr)))));

   assert_load_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      time_load |-> $past(wr_valid && !addr_valid && we_flag && ptr <= TIME_LAST));

   assert_load_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !addr_valid && ptr <= TIME_LAST && !we_flag) |=> !time_load);

   assert_snap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_start |=> $stable(snap_flat));
endmodule

bind rbk_bank rbk_bank_chk #(.DW(DW), .AW(AW), .NUM_REGS(NUM_REGS), .TIME_CNT(TIME_CNT)) u_chk (
   .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .addr_valid(addr_valid),
   .addr_byte(addr_byte), .wr_valid(wr_valid), .rd_req(rd_req), .rd_valid(rd_valid),
   .time_load(time_load), .ptr(ptr), .we_flag(we_flag), .snap_flat(snap_flat));

// File: tb/rbk_bank_tb.sv
module rbk_bank_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xfer_start = 1'b0, addr_valid = 1'b0, wr_valid = 1'b0, rd_req = 1'b0;
   logic [7:0]  addr_byte = '0, wr_data = '0;
   logic [55:0] time_in = '0;
   logic        rd_valid, time_load;
   logic [7:0]  rd_data, time_load_val;
   logic [2:0]  time_load_idx;

   int n_tests = 0, n_fail = 0, cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rbk_bank u_dut (
      .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .addr_valid(addr_valid),
      .addr_byte(addr_byte), .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
      .time_in(time_in), .rd_valid(rd_valid), .rd_data(rd_data), .time_load(time_load),
      .time_load_idx(time_load_idx), .time_load_val(time_load_val));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [55:0] pack_time(input logic [7:0] b0, b1, b2, b3, b4, b5, b6);
      return {b6, b5, b4, b3, b2, b1, b0};
   endfunction

   task automatic start_xfer();
      @(negedge clk) xfer_start = 1'b1;
      @(negedge clk) xfer_start = 1'b0;
   endtask

   task automatic set_addr(input logic [7:0] a);
      @(negedge clk) begin addr_valid = 1'b1; addr_byte = a; end
      @(negedge clk) addr_valid = 1'b0;
   endtask

   task automatic wr_byte(input logic [7:0] d);
      @(negedge clk) begin wr_valid = 1'b1; wr_data = d; end
      @(negedge clk) wr_valid = 1'b0;
   endtask

   task automatic rd_byte(output logic [7:0] d, output logic v);
      @(negedge clk) rd_req = 1'b1;
      @(negedge clk) rd_req = 1'b0;
      d = rd_data;
      v = rd_valid;
   endtask

   task automatic expect_rd(input string req, input logic [7:0] exp);
      logic [7:0] d;
      logic v;
      rd_byte(d, v);
      check({req, " rd_valid"}, 32'(v), 32'd1);
      check(req, 32'(d), 32'(exp));
   endtask

   task automatic t_reset();
      check("R1 rd_valid", 32'(rd_valid), 0);
      check("R1 time_load", 32'(time_load), 0);
      expect_rd("R1 shadow 00h", 8'h00);
      set_addr(8'h03);
      expect_rd("R1 shadow date", 8'h01);
      set_addr(8'h0C);
      expect_rd("R1 alarm 0Ch", 8'h00);
   endtask

   task automatic t_store();
      start_xfer();
      set_addr(8'h12);
      wr_byte(8'hAA);
      check("R7 no load on user write", 32'(time_load), 0);
      wr_byte(8'hBB);
      set_addr(8'h12);
      expect_rd("R7 user 12h", 8'hAA);
      expect_rd("R3 next 13h", 8'hBB);
   endtask

   task automatic t_addr_ignore();
      set_addr(8'h12);
      set_addr(8'h1A);
      expect_rd("R2 1Ah ignored", 8'hAA);
      set_addr(8'hFF);
      expect_rd("R2 FFh ignored", 8'hBB);
   endtask

   task automatic t_protect();
      start_xfer();
      set_addr(8'h00);
      wr_byte(8'h55);
      check("R6 blocked load", 32'(time_load), 0);
      set_addr(8'h07);
      wr_byte(8'h10);
      check("R7 ctrl write no load", 32'(time_load), 0);
      set_addr(8'h07);
      expect_rd("R7 ctrl readback", 8'h10);
      set_addr(8'h02);
      wr_byte(8'h23);
      check("R5 load pulse", 32'(time_load), 1);
      check("R5 load idx", 32'(time_load_idx), 2);
      check("R5 load val", 32'(time_load_val), 32'h23);
      @(negedge clk);
      check("R5 pulse one cycle", 32'(time_load), 0);
      set_addr(8'h07);
      wr_byte(8'h00);
      set_addr(8'h05);
      wr_byte(8'h99);
      check("R6 blocked again", 32'(time_load), 0);
      wr_byte(8'h98);
      check("R6 pointer advanced, still blocked", 32'(time_load), 0);
   endtask

   task automatic t_wrap();
      set_addr(8'h19);
      wr_byte(8'hCC);
      set_addr(8'h19);
      expect_rd("R4 user 19h", 8'hCC);
      expect_rd("R4 wrap 19h->12h", 8'hAA);
      set_addr(8'h0B);
      wr_byte(8'h3C);
      wr_byte(8'h10);
      set_addr(8'h0B);
      expect_rd("R4 ctrl 0Bh", 8'h3C);
      expect_rd("R4 wrap 0Bh->07h", 8'h10);
      set_addr(8'h11);
      wr_byte(8'h5A);
      wr_byte(8'hA5);
      set_addr(8'h0C);
      expect_rd("R4 wrap 11h->0Ch", 8'hA5);
   endtask

   task automatic t_snapshot();
      logic [7:0] va [7] = '{8'h12, 8'h34, 8'h05, 8'h17, 8'h09, 8'h26, 8'h03};
      time_in = pack_time(va[0], va[1], va[2], va[3], va[4], va[5], va[6]);
      start_xfer();
      time_in = pack_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h06);
      set_addr(8'h00);
      for (int i = 0; i < 7; i++) expect_rd("R8 snapshot held", va[i]);
      expect_rd("R4 wrap 06h->00h", va[0]);
      @(negedge clk) begin
         xfer_start = 1'b1;
         time_in = pack_time(8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h00);
      end
      @(negedge clk) xfer_start = 1'b0;
      set_addr(8'h00);
      expect_rd("R8 same-edge capture", 8'h01);
   endtask

   task automatic t_curaddr();
      start_xfer();
      set_addr(8'h14);
      wr_byte(8'hDD);
      wr_byte(8'hEE);
      start_xfer();
      set_addr(8'h13);
      expect_rd("R9 13h", 8'hBB);
      expect_rd("R9 14h", 8'hDD);
      start_xfer();
      expect_rd("R9 current address 15h", 8'hEE);
   endtask

   task automatic t_priority();
      logic [7:0] d;
      logic v;
      @(negedge clk) begin
         addr_valid = 1'b1; addr_byte = 8'h16; wr_valid = 1'b1; wr_data = 8'h77;
      end
      @(negedge clk) begin addr_valid = 1'b0; wr_valid = 1'b0; end
      expect_rd("R10 write lost to address", 8'h00);
      @(negedge clk) begin addr_valid = 1'b1; addr_byte = 8'h12; rd_req = 1'b1; end
      @(negedge clk) begin addr_valid = 1'b0; rd_req = 1'b0; end
      check("R10 read lost to address", 32'(rd_valid), 0);
      expect_rd("R10 pointer not stepped", 8'hAA);
      set_addr(8'h12);
      @(negedge clk) begin wr_valid = 1'b1; wr_data = 8'h42; rd_req = 1'b1; end
      @(negedge clk) begin wr_valid = 1'b0; rd_req = 1'b0; end
      check("R10 read lost to write", 32'(rd_valid), 0);
      rd_byte(d, v);
      check("R10 write stepped to 13h", 32'(d), 32'hBB);
      set_addr(8'h12);
      expect_rd("R10 write stored", 8'h42);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected <= %0d cycles", cycles, WATCHDOG);
         $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_store();
      t_addr_ignore();
      t_protect();
      t_wrap();
      t_snapshot();
      t_curaddr();
      t_priority();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule